// File: doc/BRIEF.md
# Interrupt Request Masking with Power-Fail Warning

This block sits between the interrupt flag bits of an 8051-style controller and its interrupt sequencer. It combines the pending source flags with the software enable register and produces a masked request vector. It also picks the source that should be serviced first and gives that source's vector address. The sequencer that fetches the vector and tracks nesting takes these outputs.

A sixth source carries a power-fail warning. It is latched from the falling edge of an active-low supply-monitor pin, after that pin passes through a synchronizer. The source ignores the global enable and is gated only by its own enable bit. It always outranks the five standard sources. A read of the power-control register clears the latched warning.

The block also drives the wake-up strobes. Any pending enabled request asks the core to leave idle. In the default variant, external interrupts do not bring the core out of power-down.

Top module: `intreq_gate`

## Requirements
- R1: `req_vec` bit positions are fixed: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial (receive flag OR transmit flag), bit 5 power-fail warning. Bit i (0..4) is set only when its flag is set and `en_reg[i]` is 1.
- R2: When `en_reg[7]` (global enable) is 0, `req_vec[4:0]` is all zero whatever the flags and per-source enables are.
- R3: `req_vec[5]` equals `pfw_flag AND pf_en`, and `en_reg[7]` has no effect on it.
- R4: `top_valid` is 1 when any `req_vec` bit is set. `top_idx` is 5 whenever `req_vec[5]` is set. Otherwise `top_idx` is the lowest-numbered pending source whose `prio_reg` bit is 1, and if there is none, the lowest-numbered pending source.
- R5: `vec_addr` is 8*`top_idx`+3 when `top_valid` is 1, so the power-fail warning maps to 0x2B. `vec_addr` is 0 when nothing is pending.
- R6: A high-to-low change on `pf_pin_n` sets `pfw_flag` on the third rising clock edge after the change (two synchronizer stages, then edge detection). A low-to-high change never sets it.
- R7: `pcon_rd` clears `pfw_flag` on the next edge. If a detected falling edge arrives in the same cycle, the set wins and the flag stays 1.
- R8: `idle_clr` is 1 exactly when `idle_bit` is 1 and at least one `req_vec` bit is set, the power-fail bit included.
- R9: In the default variant, `pd_clr` stays 0 while `pd_bit` is 1 and enabled external requests are pending.
- R10: After reset `pfw_flag` is 0. With all flags low, `req_vec`, `top_valid` and `vec_addr` are 0.

Top module ports are listed in order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext0_flag | input | 1 | External interrupt 0 pending |
| tmr0_flag | input | 1 | Timer 0 overflow pending |
| ext1_flag | input | 1 | External interrupt 1 pending |
| tmr1_flag | input | 1 | Timer 1 overflow pending |
| rx_flag | input | 1 | Serial receive complete |
| tx_flag | input | 1 | Serial transmit complete |
| en_reg | input | 8 | Enable register: bit 7 global, bits 4:0 per source |
| prio_reg | input | 5 | Per-source high-priority select for bits 0..4 |
| pf_en | input | 1 | Power-fail warning enable |
| pf_pin_n | input | 1 | Raw power-fail pin, active low, asynchronous |
| pcon_rd | input | 1 | Power-control register read strobe, clears the warning |
| idle_bit | input | 1 | Core is in idle |
| pd_bit | input | 1 | Core is in power-down |
| req_vec | output | 6 | Masked request vector |
| pfw_flag | output | 1 | Latched power-fail warning |
| top_valid | output | 1 | Some request is pending |
| top_idx | output | 3 | Index of the request to serve first |
| vec_addr | output | 8 | Vector address of that request |
| idle_clr | output | 1 | Strobe to leave idle |
| pd_clr | output | 1 | Strobe to leave power-down |

## Verification
A wrong synchronizer depth or a wrong edge polarity shows at `pfw_flag` one edge early, one edge late, or on the release of the pin. A flag that is cleared when it should be set shows one edge after the clear strobe. A wrong gating term or a wrong priority order shows at once on `req_vec`, `top_idx` and `vec_addr`, in the same cycle the inputs change. The directed sequences therefore sample the warning flag on every edge around the pin change, and the table sweeps the enable and priority patterns that separate each bit and each ordering.

// File: rtl/intreq_pkg.sv
package intreq_pkg;
   localparam int unsigned STD_SRC_N  = 5;
   localparam int unsigned ALL_SRC_N  = STD_SRC_N + 1;
   localparam int unsigned PF_SLOT    = STD_SRC_N;
   localparam int unsigned PF_LEVEL   = 3;
   typedef logic [ALL_SRC_N-1:0] req_vec_t;
endpackage

// File: rtl/pfw_detect.sv
module pfw_detect #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic clr,
   output logic flag
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   fall;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("pfw_detect: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag <= 1'b0;
      else if (fall)  flag <= 1'b1;
      else if (clr)   flag <= 1'b0;
   end

   p_fall_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> flag);
   p_rise_from_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(fall));
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !fall) |=> !flag);
endmodule

// File: rtl/req_masker.sv
module req_masker #(
   parameter int unsigned STD_N   = 5,
   parameter int unsigned EN_W    = 8,
   parameter int unsigned GIE_BIT = 7
) (
   input  logic [STD_N-1:0] src,
   input  logic [EN_W-1:0]  en_reg,
   input  logic             pf_flag,
   input  logic             pf_en,
   output logic [STD_N:0]   req
);
   logic gie;

   generate
      if (GIE_BIT >= EN_W || STD_N > GIE_BIT) begin : g_bad_layout
         $error("req_masker: enable register layout inconsistent");
      end
   endgenerate

   assign gie = en_reg[GIE_BIT];

   for (genvar i = 0; i < STD_N; i++) begin : g_std
      assign req[i] = src[i] & en_reg[i] & gie;
   end

   assign req[STD_N] = pf_flag & pf_en;
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
   parameter int unsigned N          = 6,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8
) (
   input  logic [N-1:0]         req,
   input  logic [N-2:0]         hi_sel,
   output logic                 valid,
   output logic [$clog2(N)-1:0] idx,
   output logic [ADDR_W-1:0]    addr
);
   localparam int unsigned IDX_W = $clog2(N);

   generate
      if (VEC_BASE + (N-1)*VEC_STRIDE >= (1 << ADDR_W)) begin : g_bad_addr
         $error("prio_pick: vector table exceeds ADDR_W");
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = N-2; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
      for (int i = N-2; i >= 0; i--) begin
         if (req[i] && hi_sel[i]) idx = IDX_W'(i);
      end
      if (req[N-1]) idx = IDX_W'(N-1);
   end

   assign valid = |req;
   assign addr  = valid ? (ADDR_W'(VEC_BASE) + ADDR_W'(idx) * ADDR_W'(VEC_STRIDE))
                        : '0;
endmodule

// File: rtl/intreq_gate.sv
module intreq_gate
   import intreq_pkg::*;
#(
   parameter int unsigned EN_W         = 8,
   parameter int unsigned GIE_BIT      = 7,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned VEC_BASE     = 3,
   parameter int unsigned VEC_STRIDE   = 8,
   parameter bit          EXT_WAKES_PD = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ext0_flag,
   input  logic                         tmr0_flag,
   input  logic                         ext1_flag,
   input  logic                         tmr1_flag,
   input  logic                         rx_flag,
   input  logic                         tx_flag,
   input  logic [EN_W-1:0]              en_reg,
   input  logic [STD_SRC_N-1:0]         prio_reg,
   input  logic                         pf_en,
   input  logic                         pf_pin_n,
   input  logic                         pcon_rd,
   input  logic                         idle_bit,
   input  logic                         pd_bit,
   output logic [ALL_SRC_N-1:0]         req_vec,
   output logic                         pfw_flag,
   output logic                         top_valid,
   output logic [$clog2(ALL_SRC_N)-1:0] top_idx,
   output logic [ADDR_W-1:0]            vec_addr,
   output logic                         idle_clr,
   output logic                         pd_clr
);
   localparam int unsigned IDX_W = $clog2(ALL_SRC_N);

   logic [STD_SRC_N-1:0] src;
   req_vec_t             req_w;

   assign src = {rx_flag | tx_flag, tmr1_flag, ext1_flag, tmr0_flag, ext0_flag};

   pfw_detect #(.SYNC_STAGES(SYNC_STAGES)) u_pfw (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n (pf_pin_n),
      .clr   (pcon_rd),
      .flag  (pfw_flag)
   );

   req_masker #(.STD_N(STD_SRC_N), .EN_W(EN_W), .GIE_BIT(GIE_BIT)) u_mask (
      .src     (src),
      .en_reg  (en_reg),
      .pf_flag (pfw_flag),
      .pf_en   (pf_en),
      .req     (req_w)
   );

   prio_pick #(.N(ALL_SRC_N), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE),
               .VEC_STRIDE(VEC_STRIDE)) u_pick (
      .req    (req_w),
      .hi_sel (prio_reg),
      .valid  (top_valid),
      .idx    (top_idx),
      .addr   (vec_addr)
   );

   assign req_vec  = req_w;
   assign idle_clr = idle_bit & (|req_w);

   generate
      if (EXT_WAKES_PD) begin : g_pd_wake
         assign pd_clr = pd_bit & (req_w[0] | req_w[2]);
      end else begin : g_pd_hold
         assign pd_clr = 1'b0;
      end
   endgenerate

   p_gie_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_reg[GIE_BIT] |-> (req_vec[STD_SRC_N-1:0] == '0));
   p_pf_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pfw_flag && pf_en) |-> req_vec[PF_SLOT]);
   p_pf_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_vec[PF_SLOT] |-> (top_idx == IDX_W'(PF_SLOT)));
   p_idle_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_bit && (|req_vec)) |-> idle_clr);
   p_pd_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pd_clr |-> pd_bit);
endmodule

// File: tb/intreq_gate_bench.sv
`timescale 1ns/1ps
module intreq_gate_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext0_flag = 0, tmr0_flag = 0, ext1_flag = 0, tmr1_flag = 0;
   logic       rx_flag = 0, tx_flag = 0;
   logic [7:0] en_reg = 8'h00;
   logic [4:0] prio_reg = 5'h00;
   logic       pf_en = 0, pf_pin_n = 1, pcon_rd = 0, idle_bit = 0, pd_bit = 0;
   logic [5:0] req_vec;
   logic       pfw_flag, top_valid, idle_clr, pd_clr;
   logic [2:0] top_idx;
   logic [7:0] vec_addr;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   intreq_gate u_intreq_gate (
      .clk(clk), .rst_n(rst_n),
      .ext0_flag(ext0_flag), .tmr0_flag(tmr0_flag), .ext1_flag(ext1_flag),
      .tmr1_flag(tmr1_flag), .rx_flag(rx_flag), .tx_flag(tx_flag),
      .en_reg(en_reg), .prio_reg(prio_reg), .pf_en(pf_en), .pf_pin_n(pf_pin_n),
      .pcon_rd(pcon_rd), .idle_bit(idle_bit), .pd_bit(pd_bit),
      .req_vec(req_vec), .pfw_flag(pfw_flag), .top_valid(top_valid),
      .top_idx(top_idx), .vec_addr(vec_addr), .idle_clr(idle_clr), .pd_clr(pd_clr)
   );

   typedef struct packed {
      logic [5:0] fl;   // {tx, rx, tmr1, ext1, tmr0, ext0}
      logic [7:0] en;
      logic [4:0] pr;
      logic [5:0] ereq;
      logic [2:0] eidx;
   } vec_t;

   localparam vec_t TBL [8] = '{
      '{6'b000001, 8'h81, 5'b00000, 6'b000001, 3'd0},
      '{6'b111111, 8'h9F, 5'b00000, 6'b011111, 3'd0},
      '{6'b111111, 8'h1F, 5'b00000, 6'b000000, 3'd0},
      '{6'b111111, 8'h9F, 5'b01000, 6'b011111, 3'd3},
      '{6'b010000, 8'h90, 5'b00000, 6'b010000, 3'd4},
      '{6'b100000, 8'h90, 5'b00000, 6'b010000, 3'd4},
      '{6'b001100, 8'h88, 5'b00000, 6'b001000, 3'd3},
      '{6'b000101, 8'h85, 5'b00100, 6'b000101, 3'd2}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_flags(input logic [5:0] f);
      {tx_flag, rx_flag, tmr1_flag, ext1_flag, tmr0_flag, ext0_flag} = f;
   endtask

   initial begin
      #1600000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R10 reset state
      chk("R10 flag", pfw_flag, 0);
      chk("R10 req", req_vec, 0);
      chk("R10 valid", top_valid, 0);
      chk("R10 addr", vec_addr, 0);

      // R1 R2 R4 R5 table sweep
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         set_flags(TBL[i].fl);
         en_reg   = TBL[i].en;
         prio_reg = TBL[i].pr;
         #1;
         chk("R1/R2 req", req_vec, TBL[i].ereq);
         chk("R4 valid", top_valid, (TBL[i].ereq != 0));
         if (TBL[i].ereq != 0) begin
            chk("R4 idx", top_idx, TBL[i].eidx);
            chk("R5 addr", vec_addr, 8 * TBL[i].eidx + 3);
         end else begin
            chk("R5 addr none", vec_addr, 0);
         end
      end

      // R6 falling edge timing
      @(negedge clk);
      set_flags(6'b000001); en_reg = 8'h81; prio_reg = 5'b00001; pf_en = 0;
      pf_pin_n = 0;
      @(negedge clk);
      chk("R6 after 1 edge", pfw_flag, 0);
      @(negedge clk);
      chk("R6 after 2 edges", pfw_flag, 0);
      @(negedge clk);
      chk("R6 after 3 edges", pfw_flag, 1);
      chk("R3 pf_en off", req_vec[5], 0);
      pf_en = 1; en_reg = 8'h01; #1;
      chk("R3 bypass gie", req_vec, 6'b100000);
      chk("R5 pf addr", vec_addr, 8'h2B);
      en_reg = 8'h81; #1;
      chk("R4 pf outranks high", top_idx, 5);
      // R8 idle wake
      en_reg = 8'h00; idle_bit = 1; #1;
      chk("R8 idle on pf", idle_clr, 1);
      // R9 power-down hold
      en_reg = 8'h85; set_flags(6'b000101); pd_bit = 1; #1;
      chk("R9 pd held", pd_clr, 0);

      // R7 clear
      @(negedge clk);
      pcon_rd = 1;
      @(negedge clk);
      pcon_rd = 0;
      chk("R7 cleared", pfw_flag, 0);
      pf_en = 0; en_reg = 8'h00; #1;
      chk("R8 idle no req", idle_clr, 0);
      idle_bit = 0; pd_bit = 0;

      // R6 release never sets
      pf_pin_n = 1;
      repeat (4) @(negedge clk);
      chk("R6 rise ignored", pfw_flag, 0);

      // R7 set wins over clear
      pf_pin_n = 0;
      @(negedge clk);
      @(negedge clk);
      pcon_rd = 1;
      @(negedge clk);
      pcon_rd = 0;
      chk("R7 set beats clear", pfw_flag, 1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule